// File: doc/BRIEF.md
# Bidirectional Token Row-Scan Shifter

This block sequences the row-select lines of a passive-matrix display. A single token bit is clocked into a chain of row cells and advances one row per rising clock edge, so each row is selected in turn. The row-select outputs are active low: a row whose cell holds the token pulls its line low, and every other row stays high. Shift direction, the number of tokens (one or two), and the usable row span (the full chain, or a shorter span that leaves a few rows unused at each end) are static configuration inputs. Change them only while reset is held.

Each end of the chain has a token pin that can act as input or output. The pin at the entry end accepts the token. The pin at the far end signals that the token is about to leave, so a second device can be chained after this one. In dual mode one input pulse places two tokens: one at the entry end and one at the centre. The two halves of the chain then scan side by side without handing tokens across the centre. A precharge-bar input can blank all rows. When it is sampled low at a clock edge, every row goes high until the input returns high, and the selected row then reappears at once.

Top module: `row_scan_shifter`

## Requirements
- R1: While `rst_n` is low, all stored tokens are cleared at once, without waiting for a clock edge. All bits of `row_n_o` read 1, and both token outputs read 0.
- R2: With `dir_right`=1 and `full_rows`=1, a 1 on `right_tok_i` at a rising edge puts the token in row 0. Each later edge moves every token up by one row index.
- R3: With `dir_right`=0 and `full_rows`=1, a 1 on `left_tok_i` at a rising edge puts the token in row 127. Each later edge moves every token down by one row index.
- R4: With `full_rows`=0, the entry row is 4 (shift up) or 123 (shift down). The span ends at row 123 or row 4. Rows 0..3 and 124..127 always read 1.
- R5: With `dual_mode`=1, one entry pulse places two tokens. Shifting up, they land in the entry row and row 64. Shifting down, they land in the entry row and row 63.
- R6: In dual mode, no token crosses the centre. Shifting up, a token in row 63 is dropped at the next edge. Shifting down, a token in row 64 is dropped at the next edge.
- R7: The output pin at the far end reads 1 exactly while the last row of the span holds a token, and 0 otherwise. When shifting up this is `left_tok_o` and the last row is 127 or 123. When shifting down this is `right_tok_o` and the last row is 0 or 4.
- R8: `left_tok_oe` equals `dir_right` and `right_tok_oe` equals its inverse. The output value of the pin acting as input reads 0.
- R9: If `pre_n` is 0 at a rising edge, all rows read 1 for as long as `pre_n` stays 0. When `pre_n` returns to 1, the row holding the token reads 0 again without waiting for a clock edge. A `pre_n` held at 1 blanks nothing.
- R10: If a token is entered only while no token is stored, at most one row reads 0 in single mode and at most two in dual mode.
- R11: The token pin that is not the input for the selected direction has no effect on the rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; tokens move on the rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all tokens and the blanking flag |
| dir_right | input | 1 | 1: token enters at the right pin and moves to higher rows; 0: the reverse |
| dual_mode | input | 1 | 1: each entry pulse places a second token at the centre |
| full_rows | input | 1 | 1: rows 0..127 are used; 0: rows 4..123 are used |
| pre_n | input | 1 | Precharge request, active low, sampled at rising edges |
| right_tok_i | input | 1 | Right pin, input side |
| right_tok_o | output | 1 | Right pin, output side (token exit when shifting down) |
| right_tok_oe | output | 1 | Right pin output enable |
| left_tok_i | input | 1 | Left pin, input side |
| left_tok_o | output | 1 | Left pin, output side (token exit when shifting up) |
| left_tok_oe | output | 1 | Left pin output enable |
| row_n_o | output | 128 | Row enables, 0 = row selected |

## Verification
The bench targets the boundaries of the span.

- It runs a token to the last row of the shorter span. A design that ignored the span would carry the token on into rows 124..127 or 0..3.
- It runs both dual-mode halves across the centre. A design that carried tokens across would light row 64 or row 63 after the lower token expires.
- It checks the exit flag in the one cycle it should be high. A flag that is late or early by one cycle would make a chained device lose the token or take it twice.
- It drops `pre_n` in the middle of a row. A design that blanked on the level rather than on the sampled edge would hide the row too early; a design that waited for a clock to release the blanking would keep the row dark after `pre_n` rises.
- It pulses the unused pin, which a design that merged both pins would treat as a token entry.

// File: rtl/rss_pkg.sv
package rss_pkg;

    // Static scan configuration, held stable outside reset.
    typedef struct packed {
        logic dir_right;  // 1: tokens move toward higher row indices
        logic dual;       // 1: second token seeded at the centre
        logic full;       // 1: whole chain used, 0: trimmed span
    } scan_cfg_t;

endpackage

// File: rtl/rss_range_decode.sv
module rss_range_decode
    import rss_pkg::*;
#(
    parameter  int NUM_ROWS = 128,
    parameter  int TRIM     = 4,
    localparam int IDX_W    = $clog2(NUM_ROWS)
) (
    input  scan_cfg_t            cfg,
    output logic [IDX_W-1:0]     entry_idx,
    output logic [IDX_W-1:0]     exit_idx,
    output logic [IDX_W-1:0]     mid_idx,
    output logic [NUM_ROWS-1:0]  valid_mask
);

    localparam int HALF = NUM_ROWS / 2;
    localparam logic [IDX_W-1:0] LO_FULL  = '0;
    localparam logic [IDX_W-1:0] HI_FULL  = IDX_W'(NUM_ROWS - 1);
    localparam logic [IDX_W-1:0] LO_SHORT = IDX_W'(TRIM);
    localparam logic [IDX_W-1:0] HI_SHORT = IDX_W'(NUM_ROWS - 1 - TRIM);
    localparam logic [IDX_W-1:0] MID_UP   = IDX_W'(HALF);
    localparam logic [IDX_W-1:0] MID_DN   = IDX_W'(HALF - 1);

    logic [IDX_W-1:0] span_lo;
    logic [IDX_W-1:0] span_hi;

    always_comb begin
        span_lo   = cfg.full ? LO_FULL : LO_SHORT;
        span_hi   = cfg.full ? HI_FULL : HI_SHORT;
        entry_idx = cfg.dir_right ? span_lo : span_hi;
        exit_idx  = cfg.dir_right ? span_hi : span_lo;
        mid_idx   = cfg.dir_right ? MID_UP  : MID_DN;
    end

    // A row is usable either in full mode or when inside the trimmed span.
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_valid
        localparam bit IN_SHORT = (g >= TRIM) && (g <= NUM_ROWS - 1 - TRIM);
        assign valid_mask[g] = cfg.full | IN_SHORT;
    end

endmodule

// File: rtl/rss_shift_core.sv
module rss_shift_core #(
    parameter  int NUM_ROWS = 128,
    localparam int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_right,
    input  logic                 dual,
    input  logic                 tok_in,
    input  logic [IDX_W-1:0]     entry_idx,
    input  logic [IDX_W-1:0]     mid_idx,
    input  logic [NUM_ROWS-1:0]  valid_mask,
    output logic [NUM_ROWS-1:0]  cells_q
);

    localparam int HALF = NUM_ROWS / 2;

    typedef struct packed {
        logic [NUM_ROWS-1:0] cells;
    } core_t;

    core_t st_d;
    core_t st_q;

    logic [NUM_ROWS-1:0] seed;
    logic [NUM_ROWS-1:0] from_below;
    logic [NUM_ROWS-1:0] from_above;
    logic [NUM_ROWS-1:0] moved;

    // One-hot entry cell, plus the centre cell when two tokens are used.
    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_seed
        assign seed[g] = (entry_idx == IDX_W'(g)) | (dual & (mid_idx == IDX_W'(g)));
    end

    always_comb begin
        from_below = {st_q.cells[NUM_ROWS-2:0], 1'b0};
        from_above = {1'b0, st_q.cells[NUM_ROWS-1:1]};
        // Dual mode splits the chain: nothing crosses the centre.
        if (dual) begin
            from_below[HALF]   = 1'b0;
            from_above[HALF-1] = 1'b0;
        end
        moved      = dir_right ? from_below : from_above;
        st_d.cells = (moved | ({NUM_ROWS{tok_in}} & seed)) & valid_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cells_q = st_q.cells;

endmodule

// File: rtl/rss_precharge_gate.sv
module rss_precharge_gate #(
    parameter int NUM_ROWS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_n,
    input  logic [NUM_ROWS-1:0]  cells,
    input  logic [NUM_ROWS-1:0]  valid_mask,
    output logic [NUM_ROWS-1:0]  row_n
);

    typedef struct packed {
        logic blank;
    } pc_t;

    pc_t  pc_d;
    pc_t  pc_q;
    logic mask_now;

    always_comb begin
        pc_d.blank = ~pre_n;
        // Released without a clock as soon as the request goes away.
        mask_now   = pc_q.blank & ~pre_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    for (genvar g = 0; g < NUM_ROWS; g++) begin : g_row
        assign row_n[g] = ~(cells[g] & valid_mask[g] & ~mask_now);
    end

endmodule

// File: rtl/row_scan_shifter.sv
module row_scan_shifter
    import rss_pkg::*;
#(
    parameter  int NUM_ROWS = 128,
    parameter  int TRIM     = 4,
    localparam int IDX_W    = $clog2(NUM_ROWS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_right,
    input  logic                 dual_mode,
    input  logic                 full_rows,
    input  logic                 pre_n,
    input  logic                 right_tok_i,
    output logic                 right_tok_o,
    output logic                 right_tok_oe,
    input  logic                 left_tok_i,
    output logic                 left_tok_o,
    output logic                 left_tok_oe,
    output logic [NUM_ROWS-1:0]  row_n_o
);

    scan_cfg_t           cfg;
    logic [IDX_W-1:0]    entry_idx;
    logic [IDX_W-1:0]    exit_idx;
    logic [IDX_W-1:0]    mid_idx;
    logic [NUM_ROWS-1:0] valid_mask;
    logic [NUM_ROWS-1:0] cells;
    logic                tok_in;
    logic                exit_bit;

    always_comb begin
        cfg.dir_right = dir_right;
        cfg.dual      = dual_mode;
        cfg.full      = full_rows;
        tok_in        = dir_right ? right_tok_i : left_tok_i;
    end

    rss_range_decode #(
        .NUM_ROWS (NUM_ROWS),
        .TRIM     (TRIM)
    ) u_range (
        .cfg        (cfg),
        .entry_idx  (entry_idx),
        .exit_idx   (exit_idx),
        .mid_idx    (mid_idx),
        .valid_mask (valid_mask)
    );

    rss_shift_core #(
        .NUM_ROWS (NUM_ROWS)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_right  (dir_right),
        .dual       (dual_mode),
        .tok_in     (tok_in),
        .entry_idx  (entry_idx),
        .mid_idx    (mid_idx),
        .valid_mask (valid_mask),
        .cells_q    (cells)
    );

    rss_precharge_gate #(
        .NUM_ROWS (NUM_ROWS)
    ) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_n      (pre_n),
        .cells      (cells),
        .valid_mask (valid_mask),
        .row_n      (row_n_o)
    );

    // The far-end cell flags the departure one edge ahead of the next device.
    always_comb begin
        exit_bit     = cells[exit_idx];
        left_tok_oe  = dir_right;
        right_tok_oe = ~dir_right;
        left_tok_o   = dir_right & exit_bit;
        right_tok_o  = ~dir_right & exit_bit;
    end

endmodule

// File: rtl/rss_checker.sv
module rss_checker #(
    parameter int NUM_ROWS = 128,
    parameter int TRIM     = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 dir_right,
    input logic                 full_rows,
    input logic                 pre_n,
    input logic                 right_tok_o,
    input logic                 right_tok_oe,
    input logic                 left_tok_o,
    input logic                 left_tok_oe,
    input logic [NUM_ROWS-1:0]  row_n_o
);

    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (&row_n_o && !left_tok_o && !right_tok_o)); // R1

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pre_n && dir_right && $past(dir_right) && $stable(full_rows) && $past(!row_n_o[5]))
        |-> !row_n_o[6]); // R2

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pre_n && !dir_right && $past(!dir_right) && $stable(full_rows) && $past(!row_n_o[6]))
        |-> !row_n_o[5]); // R3

    AST_TRIM_EDGES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !full_rows |-> (&row_n_o[TRIM-1:0] && &row_n_o[NUM_ROWS-1 -: TRIM])); // R4

    AST_EXIT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && dir_right && full_rows && !row_n_o[NUM_ROWS-1]) |-> left_tok_o); // R7

    AST_EXIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !dir_right && full_rows && !row_n_o[0]) |-> right_tok_o); // R7

    AST_OE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (left_tok_oe == dir_right) && (right_tok_oe == !dir_right)
        && !(right_tok_o && dir_right) && !(left_tok_o && !dir_right)); // R8

    AST_PRECHARGE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !pre_n && $past(!pre_n)) |-> &row_n_o); // R9

endmodule

bind row_scan_shifter rss_checker #(
    .NUM_ROWS (NUM_ROWS),
    .TRIM     (TRIM)
) u_rss_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .dir_right    (dir_right),
    .full_rows    (full_rows),
    .pre_n        (pre_n),
    .right_tok_o  (right_tok_o),
    .right_tok_oe (right_tok_oe),
    .left_tok_o   (left_tok_o),
    .left_tok_oe  (left_tok_oe),
    .row_n_o      (row_n_o)
);

// File: tb/row_scan_shifter_bench.sv
`timescale 1ns/1ps
module row_scan_shifter_bench;

    localparam int N    = 128;
    localparam int TRIM = 4;
    localparam int HALF = N / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic dir_right = 1'b1;
    logic dual_mode = 1'b0;
    logic full_rows = 1'b1;
    logic pre_n = 1'b1;
    logic right_tok_i = 1'b0;
    logic left_tok_i = 1'b0;
    logic right_tok_o, right_tok_oe, left_tok_o, left_tok_oe;
    logic [N-1:0] row_n_o;

    int checks = 0;
    int errors = 0;

    logic [N-1:0] m_cells = '0;
    logic         m_pc    = 1'b0;

    always #2.5 clk = ~clk;

    row_scan_shifter #(.NUM_ROWS(N), .TRIM(TRIM)) u_row_scan_shifter (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .dual_mode(dual_mode),
        .full_rows(full_rows), .pre_n(pre_n),
        .right_tok_i(right_tok_i), .right_tok_o(right_tok_o), .right_tok_oe(right_tok_oe),
        .left_tok_i(left_tok_i), .left_tok_o(left_tok_o), .left_tok_oe(left_tok_oe),
        .row_n_o(row_n_o)
    );

    function automatic int lo_of(logic full);
        return full ? 0 : TRIM;
    endfunction

    function automatic int hi_of(logic full);
        return full ? N - 1 : N - 1 - TRIM;
    endfunction

    // Moves each stored token per R2..R6, then adds any entered tokens.
    function automatic logic [N-1:0] step_model(logic [N-1:0] cur, logic right,
                                                logic dual, logic full, logic tin);
        logic [N-1:0] nxt = '0;
        for (int p = 0; p < N; p++) begin
            if (cur[p]) begin
                if (right) begin
                    if (!(p == hi_of(full) || (dual && p == HALF - 1))) nxt[p+1] = 1'b1;
                end else begin
                    if (!(p == lo_of(full) || (dual && p == HALF))) nxt[p-1] = 1'b1;
                end
            end
        end
        if (tin) begin
            if (right) begin
                nxt[lo_of(full)] = 1'b1;
                if (dual) nxt[HALF] = 1'b1;
            end else begin
                nxt[hi_of(full)] = 1'b1;
                if (dual) nxt[HALF-1] = 1'b1;
            end
        end
        return nxt;
    endfunction

    function automatic logic [N-1:0] exp_rows(logic [N-1:0] cells, logic pc, logic pre);
        if (pc && !pre) return '1;
        return ~cells;
    endfunction

    task automatic chk_vec(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: row_n_o=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {lo,loe,ro,roe}=%b expected %b", tag, act, exp);
        end
    endtask

    task automatic compare(string tag);
        logic ebit;
        int   lit;
        ebit = dir_right ? m_cells[hi_of(full_rows)] : m_cells[lo_of(full_rows)];
        chk_vec(tag, row_n_o, exp_rows(m_cells, m_pc, pre_n));
        chk4(tag, {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe},
             {dir_right & ebit, dir_right, ~dir_right & ebit, ~dir_right});
        lit = $countones(~row_n_o);
        checks++;
        if (lit > (dual_mode ? 2 : 1)) begin
            errors++;
            $display("FAIL R10: %0d rows selected, expected at most %0d", lit, dual_mode ? 2 : 1);
        end
    endtask

    task automatic tick(string tag);
        @(posedge clk);
        m_cells = step_model(m_cells, dir_right, dual_mode, full_rows,
                             dir_right ? right_tok_i : left_tok_i);
        m_pc = ~pre_n;
        #1;
        compare(tag);
    endtask

    task automatic drive(string tag, logic r, logic l, logic p);
        @(negedge clk);
        right_tok_i = r;
        left_tok_i  = l;
        pre_n       = p;
        #1;
        compare(tag);
    endtask

    task automatic run(string tag, int n);
        repeat (n) begin
            drive(tag, 1'b0, 1'b0, 1'b1);
            tick(tag);
        end
    endtask

    task automatic inject(string tag);
        drive(tag, dir_right, ~dir_right, 1'b1);
        tick(tag);
    endtask

    task automatic do_reset(logic right, logic dual, logic full);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        m_cells = '0;
        m_pc    = 1'b0;
        compare("R1");
        dir_right = right;
        dual_mode = dual;
        full_rows = full;
        right_tok_i = 1'b0;
        left_tok_i  = 1'b0;
        pre_n       = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_low(string tag, int a, int b);
        logic [N-1:0] e = '1;
        if (a >= 0) e[a] = 1'b0;
        if (b >= 0) e[b] = 1'b0;
        chk_vec(tag, row_n_o, e);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7351));
        #1 rst_n = 1'b0;

        // R1: reset state
        do_reset(1'b1, 1'b0, 1'b1);
        expect_low("R1", -1, -1);
        chk4("R1", {left_tok_o, right_tok_o, 2'b00}, 4'b0000);

        // R2: entry at row 0, upward motion
        inject("R2");
        expect_low("R2", 0, -1);
        run("R2", 5);
        expect_low("R2", 5, -1);

        // R1: reset clears at once, before any edge
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        expect_low("R1", -1, -1);

        // R3: entry at row 127, downward motion; R8 pin roles
        do_reset(1'b0, 1'b0, 1'b1);
        inject("R3");
        expect_low("R3", 127, -1);
        run("R3", 7);
        expect_low("R3", 120, -1);
        chk4("R8", {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe}, 4'b0001);

        // R11: inactive pin ignored
        do_reset(1'b0, 1'b0, 1'b1);
        drive("R11", 1'b1, 1'b0, 1'b1);
        tick("R11");
        expect_low("R11", -1, -1);
        run("R11", 1);
        expect_low("R11", -1, -1);

        // R4 / R7: trimmed span, upward
        do_reset(1'b1, 1'b0, 1'b0);
        inject("R4");
        expect_low("R4", 4, -1);
        run("R4", 119);
        expect_low("R4", 123, -1);
        chk4("R7", {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe}, 4'b1100);
        run("R4", 1);
        expect_low("R4", -1, -1);
        chk4("R7", {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe}, 4'b0100);

        // R5 / R6: dual, trimmed, upward
        do_reset(1'b1, 1'b1, 1'b0);
        inject("R5");
        expect_low("R5", 4, 64);
        run("R6", 59);
        expect_low("R6", 63, 123);
        chk4("R7", {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe}, 4'b1100);
        run("R6", 1);
        expect_low("R6", -1, -1);

        // R5 / R6: dual, full, downward
        do_reset(1'b0, 1'b1, 1'b1);
        inject("R5");
        expect_low("R5", 127, 63);
        run("R6", 63);
        expect_low("R6", 64, 0);
        chk4("R7", {left_tok_o, left_tok_oe, right_tok_o, right_tok_oe}, 4'b0011);
        run("R6", 1);
        expect_low("R6", -1, -1);

        // R9: precharge blanking and release
        do_reset(1'b1, 1'b0, 1'b1);
        inject("R9");
        expect_low("R9", 0, -1);
        drive("R9", 1'b0, 1'b0, 1'b0);
        expect_low("R9", 0, -1);
        tick("R9");
        expect_low("R9", -1, -1);
        drive("R9", 1'b0, 1'b0, 1'b1);
        expect_low("R9", 1, -1);
        tick("R9");
        expect_low("R9", 2, -1);

        // Random episodes: R2/R3/R4/R5/R6/R9/R10/R11 against the model
        for (int ep = 0; ep < 8; ep++) begin
            do_reset(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
            repeat (400) begin
                logic tin, other, p;
                tin   = (m_cells == '0) && ($urandom % 10 == 0);
                other = 1'($urandom % 2);
                p     = ($urandom % 4) != 0;
                drive("R10 random", dir_right ? tin : other, dir_right ? other : tin, p);
                tick("R9/R11 random");
            end
        end

        finish_run();
    end

endmodule